// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers maskable interrupt requests and non-maskable trap requests. It keeps one pending flag for each source and picks, every cycle, the single most urgent pending source. It presents that source's vector number and urgency level to the processor. A request line raised for one clock is enough: the source stays pending until the processor acknowledges it.

Every source has a fixed vector. Traps occupy the lowest vectors and the maskable sources follow them. Each maskable source carries an enable bit and a 3-bit priority field. Traps ignore both and always rank above every maskable source. The processor supplies its current running level. The block raises its interrupt line only when the selected source is more urgent than that level. When the processor acknowledges, the presented source's pending flag is dropped and the next winner appears on the following cycle.

Top module: `irqc_top`

## Requirements
- R1: After reset no source is pending, `vec_valid` is 0 and `cpu_irq` is 0.
- R2: A request line that is high at a rising clock edge marks its source pending from that edge on. The source stays pending, even after the line drops, until it is acknowledged.
- R3: Trap t has vector t (0 to NUM_TRAP-1). Maskable source i has vector NUM_TRAP+i. The selected vector is visible on `vec_num` in the cycle after the request edge.
- R4: A pending maskable source whose enable bit is 0, or whose priority field is 0, is not selectable. It stays pending and is selected once it is enabled with a non-zero priority.
- R5: The level of maskable source i is its priority field `irq_prio[3*i+2:3*i]` (1 to 7). The pending selectable source with the highest level is presented, and its level appears on `vec_level`.
- R6: Among pending selectable sources of equal level, the one with the lowest vector number is presented.
- R7: Trap t has level 15-t, so every pending trap beats every maskable source. The trap's level does not depend on any enable or priority field.
- R8: `cpu_irq` is 1 only when a source is presented and its level is strictly greater than `cpu_level`. `vec_valid` and `vec_num` show the winner either way.
- R9: When `ack` is high together with `cpu_irq`, the presented source's pending flag is cleared at that clock edge. `vec_num` holds its value for the whole acknowledge cycle, and the next winner is shown in the following cycle.
- R10: `ack` while `cpu_irq` is 0 clears nothing.
- R11: If the acknowledged source's request line is high in the acknowledge cycle, the new request wins and the source stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_req | input | NUM_TRAP | Non-maskable trap request lines |
| irq_req | input | NUM_IRQ | Maskable interrupt request lines |
| irq_en | input | NUM_IRQ | Per-source enable |
| irq_prio | input | 3*NUM_IRQ | Per-source priority, 3 bits each, 0 = off |
| cpu_level | input | 4 | Current processor running level |
| ack | input | 1 | Processor accepts the presented vector |
| cpu_irq | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Some selectable source is pending |
| vec_num | output | VEC_W | Vector of the presented source |
| vec_level | output | 4 | Level of the presented source |

## Verification
Two events can land on the same clock edge: the acknowledge that clears the presented source, and a fresh request that sets a pending flag. The request may come from the very source being acknowledged, or from a more urgent source. The bench provokes both cases. Directed steps assert `ack` together with the same source's request line, and the random phase frequently overlaps acknowledges with new requests. Each case is judged against a bench model in which the clear is applied first and the new request is merged after it, so the model shows which source must be presented on the next cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LVL_W  = 4;
  localparam int PRIO_W = 3;

  // Level of a trap: the top of the level range, counting down by trap index.
  function automatic logic [LVL_W-1:0] trap_level(input int unsigned idx);
    return LVL_W'((1 << LVL_W) - 1 - idx);
  endfunction

  // Level of a maskable source: its priority field when enabled, else 0.
  function automatic logic [LVL_W-1:0] irq_level(input logic en,
                                                 input logic [PRIO_W-1:0] prio);
    return en ? {{(LVL_W-PRIO_W){1'b0}}, prio} : '0;
  endfunction
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int N = 126
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // A set on the same edge as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  assert_req_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & clr_i)) |=> ((pend_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int N     = 126,
  parameter int VEC_W = 7,
  parameter int LVL_W = 4
) (
  input  logic [LVL_W-1:0] lvl_i [N],
  output logic             found_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [LVL_W-1:0] lvl_o
);
  // Scan from the top down with >=, so a tie leaves the lowest index.
  always_comb begin
    found_o = 1'b0;
    vec_o   = '0;
    lvl_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (lvl_i[i] != '0 && lvl_i[i] >= lvl_o) begin
        found_o = 1'b1;
        vec_o   = VEC_W'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end

  always_comb begin
    if (found_o) assert_winner_nonzero_R5: assert (lvl_o != '0);
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int NUM_TRAP = 8,
  parameter int NUM_IRQ  = 118,
  parameter int NUM_SRC  = NUM_TRAP + NUM_IRQ,
  parameter int VEC_W    = $clog2(NUM_SRC)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_TRAP-1:0]                  trap_req,
  input  logic [NUM_IRQ-1:0]                   irq_req,
  input  logic [NUM_IRQ-1:0]                   irq_en,
  input  logic [irqc_pkg::PRIO_W*NUM_IRQ-1:0]  irq_prio,
  input  logic [irqc_pkg::LVL_W-1:0]           cpu_level,
  input  logic                                 ack,
  output logic                                 cpu_irq,
  output logic                                 vec_valid,
  output logic [VEC_W-1:0]                     vec_num,
  output logic [irqc_pkg::LVL_W-1:0]           vec_level
);
  import irqc_pkg::*;

  logic [NUM_SRC-1:0] set_all;
  logic [NUM_SRC-1:0] clr_all;
  logic [NUM_SRC-1:0] pend;
  logic [LVL_W-1:0]   src_lvl [NUM_SRC];
  logic               ack_take;

  assign set_all = {irq_req, trap_req};

  irqc_pending #(.N(NUM_SRC)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_all),
    .clr_i (clr_all),
    .pend_o(pend)
  );

  for (genvar t = 0; t < NUM_TRAP; t++) begin : g_trap
    assign src_lvl[t] = pend[t] ? trap_level(t) : '0;
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    assign src_lvl[NUM_TRAP+i] = pend[NUM_TRAP+i]
                               ? irq_level(irq_en[i], irq_prio[PRIO_W*i +: PRIO_W])
                               : '0;
  end

  irqc_arbiter #(.N(NUM_SRC), .VEC_W(VEC_W), .LVL_W(LVL_W)) u_arb (
    .lvl_i  (src_lvl),
    .found_o(vec_valid),
    .vec_o  (vec_num),
    .lvl_o  (vec_level)
  );

  assign cpu_irq  = vec_valid && (vec_level > cpu_level);
  assign ack_take = ack && cpu_irq;
  assign clr_all  = ack_take ? (NUM_SRC'(1) << vec_num) : '0;

  assert_winner_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> pend[vec_num]);

  assert_trap_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend[NUM_TRAP-1:0]) |-> (vec_valid && vec_num < VEC_W'(NUM_TRAP) && vec_level > 4'd7));

  assert_irq_level_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_num >= VEC_W'(NUM_TRAP)) |-> (vec_level != '0 && vec_level <= 4'd7));

  assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !set_all[vec_num]) |=> !pend[$past(vec_num)]);

  assert_ack_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !cpu_irq) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

// File: tb/irqc_top_tb.sv
`timescale 1ns/1ps
module irqc_top_tb;
  localparam int NT = 8;
  localparam int NI = 118;
  localparam int NS = NT + NI;
  localparam int VW = $clog2(NS);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NT-1:0]     trap_req = '0;
  logic [NI-1:0]     irq_req = '0;
  logic [NI-1:0]     irq_en = '0;
  logic [2:0]        prio_a [NI];
  logic [3*NI-1:0]   irq_prio;
  logic [3:0]        cpu_level = '0;
  logic              ack = 1'b0;
  logic              cpu_irq, vec_valid;
  logic [VW-1:0]     vec_num;
  logic [3:0]        vec_level;
  logic [NS-1:0]     mpend = '0;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  always_comb for (int i = 0; i < NI; i++) irq_prio[3*i +: 3] = prio_a[i];

  irqc_top #(.NUM_TRAP(NT), .NUM_IRQ(NI)) u_dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .irq_req(irq_req),
    .irq_en(irq_en), .irq_prio(irq_prio), .cpu_level(cpu_level), .ack(ack),
    .cpu_irq(cpu_irq), .vec_valid(vec_valid), .vec_num(vec_num), .vec_level(vec_level)
  );

  // Ascending scan with strict > keeps the lowest vector on a tie.
  function automatic void model_win(output logic v, output int vec, output int lvl);
    v = 1'b0; vec = 0; lvl = 0;
    for (int s = 0; s < NS; s++) begin
      int l;
      if (s < NT) l = mpend[s] ? 15 - s : 0;
      else        l = (mpend[s] && irq_en[s-NT]) ? int'(prio_a[s-NT]) : 0;
      if (l > lvl) begin lvl = l; vec = s; v = 1'b1; end
    end
  endfunction

  task automatic do_check(input string tag);
    logic v; int vec, lvl; logic ei;
    model_win(v, vec, lvl);
    ei = v && (lvl > int'(cpu_level));
    checks++;
    if (vec_valid !== v || cpu_irq !== ei ||
        (v && (int'(vec_num) != vec || int'(vec_level) != lvl))) begin
      fails++;
      $display("FAIL %s actual valid=%0b irq=%0b vec=%0d lvl=%0d expected valid=%0b irq=%0b vec=%0d lvl=%0d",
               tag, vec_valid, cpu_irq, vec_num, vec_level, v, ei, vec, lvl);
    end
  endtask

  task automatic expect_out(input string tag, input logic v, input int vec,
                            input int lvl, input logic ei);
    checks++;
    if (vec_valid !== v || cpu_irq !== ei ||
        (v && (int'(vec_num) != vec || int'(vec_level) != lvl))) begin
      fails++;
      $display("FAIL %s actual valid=%0b irq=%0b vec=%0d lvl=%0d expected valid=%0b irq=%0b vec=%0d lvl=%0d",
               tag, vec_valid, cpu_irq, vec_num, vec_level, v, ei, vec, lvl);
    end
  endtask

  // Called just after a falling edge; drives one cycle of stimulus.
  task automatic tick(input logic [NT-1:0] t, input logic [NI-1:0] r, input logic a);
    logic v; int vec, lvl;
    model_win(v, vec, lvl);
    trap_req = t; irq_req = r; ack = a;
    if (a && v && lvl > int'(cpu_level)) mpend[vec] = 1'b0;
    mpend = mpend | {r, t};
    @(posedge clk);
    @(negedge clk);
    trap_req = '0; irq_req = '0; ack = 1'b0;
    #1;
  endtask

  function automatic logic [NI-1:0] bit_irq(input int i);
    return NI'(1) << i;
  endfunction

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NI; i++) prio_a[i] = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    expect_out("R1 reset idle", 1'b0, 0, 0, 1'b0);

    // R3 vector mapping of a maskable source
    irq_en[5] = 1'b1; prio_a[5] = 3'd3; cpu_level = 4'd0;
    tick('0, bit_irq(5), 1'b0);
    expect_out("R3 R2 irq5 -> vector 13", 1'b1, 13, 3, 1'b1);
    tick('0, '0, 1'b0);
    expect_out("R2 held after line drops", 1'b1, 13, 3, 1'b1);
    tick('0, '0, 1'b1);
    expect_out("R9 ack clears", 1'b0, 0, 0, 1'b0);

    // R4 masking by enable and by priority zero
    irq_en[2] = 1'b0; prio_a[2] = 3'd4;
    tick('0, bit_irq(2), 1'b0);
    expect_out("R4 enable low", 1'b0, 0, 0, 1'b0);
    irq_en[2] = 1'b1; prio_a[2] = 3'd0; #1;
    expect_out("R4 priority zero", 1'b0, 0, 0, 1'b0);
    prio_a[2] = 3'd4; #1;
    expect_out("R4 kept pending", 1'b1, 10, 4, 1'b1);
    tick('0, '0, 1'b1);

    // R6 equal levels
    irq_en[9] = 1'b1; prio_a[9] = 3'd5; irq_en[3] = 1'b1; prio_a[3] = 3'd5;
    tick('0, bit_irq(9) | bit_irq(3), 1'b0);
    expect_out("R6 tie lowest vector", 1'b1, 11, 5, 1'b1);
    tick('0, '0, 1'b1);
    expect_out("R6 R9 next after ack", 1'b1, 17, 5, 1'b1);
    tick('0, '0, 1'b1);

    // R5 highest level
    irq_en[20] = 1'b1; prio_a[20] = 3'd6; irq_en[1] = 1'b1; prio_a[1] = 3'd2;
    tick('0, bit_irq(20) | bit_irq(1), 1'b0);
    expect_out("R5 higher level wins", 1'b1, 28, 6, 1'b1);
    tick('0, '0, 1'b1);
    expect_out("R5 lower level next", 1'b1, 9, 2, 1'b1);
    tick('0, '0, 1'b1);

    // R7 traps above everything
    irq_en[7] = 1'b1; prio_a[7] = 3'd7;
    tick(NT'(1) << 3, bit_irq(7), 1'b0);
    expect_out("R7 trap over prio7", 1'b1, 3, 12, 1'b1);
    tick(NT'(1) << 6, '0, 1'b0);
    expect_out("R7 lower trap index wins", 1'b1, 3, 12, 1'b1);
    tick('0, '0, 1'b1);
    expect_out("R7 trap6 level 9", 1'b1, 6, 9, 1'b1);
    tick('0, '0, 1'b1);
    expect_out("R7 irq after traps", 1'b1, 15, 7, 1'b1);
    tick('0, '0, 1'b1);
    expect_out("R9 empty again", 1'b0, 0, 0, 1'b0);

    // R8 strict compare, R10 ignored ack, R11 same-cycle request
    irq_en[4] = 1'b1; prio_a[4] = 3'd4; cpu_level = 4'd4;
    tick('0, bit_irq(4), 1'b0);
    expect_out("R8 equal level no request", 1'b1, 12, 4, 1'b0);
    tick('0, '0, 1'b1);
    expect_out("R10 ack without request", 1'b1, 12, 4, 1'b0);
    cpu_level = 4'd3; #1;
    expect_out("R8 level above cpu", 1'b1, 12, 4, 1'b1);
    tick('0, bit_irq(4), 1'b1);
    expect_out("R11 request beats clear", 1'b1, 12, 4, 1'b1);
    tick('0, '0, 1'b1);
    expect_out("R9 cleared", 1'b0, 0, 0, 1'b0);

    // Random phase against the model
    for (int it = 0; it < 600; it++) begin
      logic [NT-1:0] t;
      logic [NI-1:0] r;
      for (int i = 0; i < NI; i++) begin
        r[i] = ($urandom % 40) == 0;
        if (($urandom % 8) == 0) begin
          irq_en[i] = ($urandom % 4) != 0;
          prio_a[i] = 3'($urandom % 8);
        end
      end
      for (int i = 0; i < NT; i++) t[i] = ($urandom % 90) == 0;
      cpu_level = 4'($urandom % 10);
      #1;
      do_check("R5 R6 R7 R8 random");
      tick(t, r, ($urandom % 3) == 0);
      do_check("R9 R11 random after tick");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule